// File: doc/BRIEF.md
# Six-Channel Double-Edge PWM with Restart-Aligned Register Update

This block produces six pulse-width modulated outputs from one shared 16-bit period counter. A 16-bit prescaler sets the counter's rate. For each output, software programs a switch-on count and a switch-off count, so both the position and the width of a pulse can be set. Because the two counts are independent, a pulse can also straddle the counter wrap.

Software writes new values into a set of system registers and arms an update request. The values reach the working (shadow) copies only at the next counter restart, so a period is never built from a mix of old and new settings. Each restart emits a one-cycle sync pulse. A second pulse, aligned with it, marks the restarts at which a copy took place, and other PWM instances can use both pulses to follow this one as master.

The block runs continuously or stops after a single period. An external restart input starts the period over. A trap input silences all six outputs at once. Per-edge match interrupts can each be enabled separately.

Top module: `pwm_dual_edge`

## Requirements
- R1: After reset, pwmOut, syncOut, transEnOut and irqOut are all 0 and the counter is idle until a run command arrives.
- R2: With period P written at address 0 and prescale S at address 1, the counter advances once every S+1 clocks and restarts after holding P, so consecutive restarts of a free-running block are (P+1)*(S+1) cycles apart.
- R3: Channel i goes high on the first clock at which the counter holds its switch-on count (address 16+2i) and goes low on the first clock at which the counter holds its switch-off count (address 17+2i). When both counts are equal the output stays low. A switch-on count above the switch-off count gives a pulse that spans the restart.
- R4: syncOut is high for exactly one cycle after each counter start: a start from idle, a wrap past the period, or an external restart.
- R5: Writes to addresses 0, 1, 16..27 change nothing at the outputs until a restart that follows a control write (address 2) with bit 2 set. At that restart all of them take effect together.
- R6: transEnOut pulses in the same cycle as syncOut, and only for a restart at which the copy of R5 took place. The request is then consumed, so later restarts do not pulse it until bit 2 is written again.
- R7: Control bit 0 is run and bit 1 is single-run. Writing run=1 from idle starts the counter. In single-run mode the block stops after the counter has held the period once: all outputs go low and no further sync pulse appears until run is written again. Writing run=0 stops the block at once.
- R8: irqOut bit 2i pulses for one cycle on the switch-on match of channel i, and bit 2i+1 pulses on its switch-off match, in the cycle the output changes. Each bit is gated by the same bit of the enable register at address 3.
- R9: trapIn high forces every pwmOut bit low in the same cycle. The outputs stay low after trapIn falls, until a control write with bit 3 set clears the latched trap.
- R10: extRestart, while the block runs, restarts the counter from 0, and syncOut pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address |
| wrData | input | 16 | Register write data |
| extRestart | input | 1 | Restart request from a master or external source |
| trapIn | input | 1 | Fault input forcing outputs low |
| pwmOut | output | 6 | PWM outputs |
| syncOut | output | 1 | One-cycle pulse at each counter start |
| transEnOut | output | 1 | One-cycle pulse when shadow values were loaded |
| irqOut | output | 12 | Per-edge match interrupt pulses |

## Verification
The hardest condition to reach is a register write that lands in the same period as a restart, or a write issued without an update request. Either way the effect only shows up one or more periods later, as a changed duty cycle or an extra transfer-enable pulse. The stimulus counts high cycles over windows that are an exact multiple of the period, before and after arming an update. The random phase then scatters writes, external restarts and traps around wraps of a short period. A cycle-by-cycle reference model in the bench follows every edge, interrupt and pulse through those collisions.

// File: rtl/pwm_de_pkg.sv
package pwm_de_pkg;

  typedef struct packed {
    logic run;         // counter is running this cycle
    logic clrCnt;      // restart or stop: counter and prescaler to zero
    logic loadShadow;  // copy system registers into shadows
    logic stopAll;     // leave running state, outputs low
    logic forceOff;    // trap: force outputs inactive
  } pwmStrobes_t;

  localparam int unsigned REG_PERIOD    = 0;
  localparam int unsigned REG_PRESCALE  = 1;
  localparam int unsigned REG_CONTROL   = 2;
  localparam int unsigned REG_IRQ_EN    = 3;
  localparam int unsigned REG_EDGE_BASE = 16;

  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_SINGLE  = 1;
  localparam int unsigned CTL_UPDATE  = 2;
  localparam int unsigned CTL_TRAPCLR = 3;

endpackage

// File: rtl/pwm_de_ctrl.sv
module pwm_de_ctrl
  import pwm_de_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWr,
  input  logic [3:0]  ctlBits,
  input  logic        extRestart,
  input  logic        trapIn,
  input  logic        tick,
  input  logic        atPeriod,
  output pwmStrobes_t stb,
  output logic        syncOut,
  output logic        transEnOut
);

  logic runReq, singleRun, updPend, trapLatched, active;
  logic wrapEv, startEv, stopEv, restartEv, loadEv;

  always_comb begin
    wrapEv    = active && tick && atPeriod;
    startEv   = runReq && !active;
    stopEv    = active && (!runReq || (wrapEv && singleRun));
    restartEv = startEv || (active && !stopEv && (extRestart || wrapEv));
    loadEv    = restartEv && updPend;

    stb.run        = active;
    stb.clrCnt     = restartEv || stopEv;
    stb.loadShadow = loadEv;
    stb.stopAll    = stopEv;
    stb.forceOff   = trapIn || trapLatched;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReq      <= 1'b0;
      singleRun   <= 1'b0;
      updPend     <= 1'b0;
      trapLatched <= 1'b0;
      active      <= 1'b0;
      syncOut     <= 1'b0;
      transEnOut  <= 1'b0;
    end else begin
      active <= startEv || (active && !stopEv);

      if (ctlWr) begin
        runReq    <= ctlBits[CTL_RUN];
        singleRun <= ctlBits[CTL_SINGLE];
      end else if (wrapEv && singleRun) begin
        runReq <= 1'b0;
      end

      if (ctlWr && ctlBits[CTL_UPDATE]) updPend <= 1'b1;
      else if (loadEv)                  updPend <= 1'b0;

      if (trapIn)                             trapLatched <= 1'b1;
      else if (ctlWr && ctlBits[CTL_TRAPCLR]) trapLatched <= 1'b0;

      syncOut    <= restartEv;
      transEnOut <= loadEv;
    end
  end

endmodule

// File: rtl/pwm_de_datapath.sv
module pwm_de_datapath
  import pwm_de_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  input  pwmStrobes_t           stb,
  output logic                  tick,
  output logic                  atPeriod,
  output logic [NUM_CH-1:0]     pwmOut,
  output logic [2*NUM_CH-1:0]   irqOut,
  output logic [CNT_W-1:0]      cntVal
);

  localparam int IRQ_W = 2 * NUM_CH;
  localparam logic [CNT_W-1:0]  CNT_STEP = CNT_W'(1);
  localparam logic [PRE_W-1:0]  PRE_STEP = PRE_W'(1);
  localparam logic [ADDR_W-1:0] A_PER    = ADDR_W'(REG_PERIOD);
  localparam logic [ADDR_W-1:0] A_PRE    = ADDR_W'(REG_PRESCALE);
  localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(REG_IRQ_EN);

  logic [CNT_W-1:0] perSys, perSh, cnt;
  logic [PRE_W-1:0] preSys, preSh, preCnt;
  logic [IRQ_W-1:0] irqEn, hitVec, irqReg;
  logic [NUM_CH-1:0] pwmState;
  logic firstSlot;

  assign tick      = (preCnt == preSh);
  assign atPeriod  = (cnt == perSh);
  assign firstSlot = stb.run && (preCnt == '0);
  assign cntVal    = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perSys <= '0; preSys <= '0; irqEn <= '0;
      perSh  <= '0; preSh  <= '0;
    end else begin
      if (wrEn && wrAddr == A_PER) perSys <= wrData;
      if (wrEn && wrAddr == A_PRE) preSys <= wrData[PRE_W-1:0];
      if (wrEn && wrAddr == A_IRQ) irqEn  <= wrData[IRQ_W-1:0];
      if (stb.loadShadow) begin
        perSh <= perSys;
        preSh <= preSys;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrCnt) begin
      cnt    <= '0;
      preCnt <= '0;
    end else if (stb.run) begin
      if (tick) begin
        preCnt <= '0;
        cnt    <= cnt + CNT_STEP;
      end else begin
        preCnt <= preCnt + PRE_STEP;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(REG_EDGE_BASE + 2 * ch);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(REG_EDGE_BASE + 2 * ch + 1);
    logic [CNT_W-1:0] riseSys, fallSys, riseSh, fallSh;
    logic riseHit, fallHit, lvl;

    assign riseHit = firstSlot && (cnt == riseSh);
    assign fallHit = firstSlot && (cnt == fallSh);
    assign hitVec[2*ch]   = riseHit;
    assign hitVec[2*ch+1] = fallHit;
    assign pwmState[ch]   = lvl;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        riseSys <= '0; fallSys <= '0;
        riseSh  <= '0; fallSh  <= '0;
        lvl     <= 1'b0;
      end else begin
        if (wrEn && wrAddr == A_RISE) riseSys <= wrData;
        if (wrEn && wrAddr == A_FALL) fallSys <= wrData;
        if (stb.loadShadow) begin
          riseSh <= riseSys;
          fallSh <= fallSys;
        end
        if (stb.stopAll)   lvl <= 1'b0;
        else if (fallHit)  lvl <= 1'b0;
        else if (riseHit)  lvl <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReg <= '0;
    else       irqReg <= hitVec & irqEn;
  end

  assign irqOut = irqReg;
  assign pwmOut = pwmState & {NUM_CH{~stb.forceOff}};

endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge
  import pwm_de_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  logic                extRestart,
  input  logic                trapIn,
  output logic [NUM_CH-1:0]   pwmOut,
  output logic                syncOut,
  output logic                transEnOut,
  output logic [2*NUM_CH-1:0] irqOut
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(REG_CONTROL);

  pwmStrobes_t      ctlStb;
  logic             tick, atPeriod, ctlWr;
  logic [CNT_W-1:0] cntVal;

  assign ctlWr = wrEn && (wrAddr == A_CTL);

  pwm_de_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctlWr      (ctlWr),
    .ctlBits    (wrData[3:0]),
    .extRestart (extRestart),
    .trapIn     (trapIn),
    .tick       (tick),
    .atPeriod   (atPeriod),
    .stb        (ctlStb),
    .syncOut    (syncOut),
    .transEnOut (transEnOut)
  );

  pwm_de_datapath #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .PRE_W  (PRE_W),
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .stb      (ctlStb),
    .tick     (tick),
    .atPeriod (atPeriod),
    .pwmOut   (pwmOut),
    .irqOut   (irqOut),
    .cntVal   (cntVal)
  );

endmodule

// File: rtl/pwm_dual_edge_chk.sv
module pwm_dual_edge_chk #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                trapIn,
  input logic [NUM_CH-1:0]   pwmOut,
  input logic                syncOut,
  input logic                transEnOut,
  input logic [2*NUM_CH-1:0] irqOut,
  input logic                active,
  input logic                clrCnt,
  input logic [CNT_W-1:0]    cnt
);

  assert_trap_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapIn |-> (pwmOut == '0));

  assert_te_with_sync_R6: assert property (@(posedge clk) disable iff (!rstN)
    transEnOut |-> syncOut);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (pwmOut == '0));

  assert_irq_needs_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> $past(active));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && !$past(clrCnt)) |->
      ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

endmodule

bind pwm_dual_edge pwm_dual_edge_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .trapIn     (trapIn),
  .pwmOut     (pwmOut),
  .syncOut    (syncOut),
  .transEnOut (transEnOut),
  .irqOut     (irqOut),
  .active     (ctlStb.run),
  .clrCnt     (ctlStb.clrCnt),
  .cnt        (cntVal)
);

// File: tb/pwm_dual_edge_tb_top.sv
module pwm_dual_edge_tb_top;
  localparam int NCH = 6;
  localparam int CW  = 16;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic extRestart = 1'b0;
  logic trapIn = 1'b0;
  logic [NCH-1:0] pwmOut;
  logic syncOut, transEnOut;
  logic [2*NCH-1:0] irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit modelCmp = 1'b0;

  always #4 clk = ~clk;

  pwm_dual_edge dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extRestart(extRestart), .trapIn(trapIn), .pwmOut(pwmOut),
    .syncOut(syncOut), .transEnOut(transEnOut), .irqOut(irqOut)
  );

  // ---------------- reference model of the requirements ----------------
  logic mAct, mRun, mOne, mUpd, mTrap, mSync, mTe;
  logic [CW-1:0] mCnt, mPre, mPer, mPerSh, mPsc, mPscSh;
  logic [CW-1:0] mRise [NCH];
  logic [CW-1:0] mFall [NCH];
  logic [CW-1:0] mRiseSh [NCH];
  logic [CW-1:0] mFallSh [NCH];
  logic [NCH-1:0] mPwm;
  logic [2*NCH-1:0] mIrqEn, mIrq, mHits;
  logic tTick, tWrap, tStart, tStop, tRestart, tLoad, tCw;

  always @(posedge clk) begin
    if (!rstN) begin
      mAct <= 0; mRun <= 0; mOne <= 0; mUpd <= 0; mTrap <= 0; mSync <= 0; mTe <= 0;
      mCnt <= 0; mPre <= 0; mPer <= 0; mPerSh <= 0; mPsc <= 0; mPscSh <= 0;
      mPwm <= 0; mIrqEn <= 0; mIrq <= 0;
      for (int c = 0; c < NCH; c++) begin
        mRise[c] <= 0; mFall[c] <= 0; mRiseSh[c] <= 0; mFallSh[c] <= 0;
      end
    end else begin
      tTick    = (mPre == mPscSh);
      tWrap    = mAct && tTick && (mCnt == mPerSh);
      tStart   = mRun && !mAct;
      tStop    = mAct && (!mRun || (tWrap && mOne));
      tRestart = tStart || (mAct && !tStop && (extRestart || tWrap));
      tLoad    = tRestart && mUpd;
      tCw      = wrEn && (wrAddr == 2);
      for (int c = 0; c < NCH; c++) begin
        mHits[2*c]   = mAct && (mPre == 0) && (mCnt == mRiseSh[c]);
        mHits[2*c+1] = mAct && (mPre == 0) && (mCnt == mFallSh[c]);
        if (tStop) mPwm[c] <= 1'b0;
        else if (mHits[2*c+1]) mPwm[c] <= 1'b0;
        else if (mHits[2*c]) mPwm[c] <= 1'b1;
      end
      mIrq  <= mHits & mIrqEn;
      mSync <= tRestart;
      mTe   <= tLoad;
      mAct  <= tStart || (mAct && !tStop);
      if (tCw) begin mRun <= wrData[0]; mOne <= wrData[1]; end
      else if (tWrap && mOne) mRun <= 1'b0;
      if (tCw && wrData[2]) mUpd <= 1'b1; else if (tLoad) mUpd <= 1'b0;
      if (trapIn) mTrap <= 1'b1; else if (tCw && wrData[3]) mTrap <= 1'b0;
      if (tRestart || tStop) begin mCnt <= 0; mPre <= 0; end
      else if (mAct) begin
        if (tTick) begin mPre <= 0; mCnt <= mCnt + 1; end
        else mPre <= mPre + 1;
      end
      if (wrEn) begin
        if (wrAddr == 0) mPer <= wrData;
        if (wrAddr == 1) mPsc <= wrData;
        if (wrAddr == 3) mIrqEn <= wrData[2*NCH-1:0];
        for (int c = 0; c < NCH; c++) begin
          if (wrAddr == AW'(16 + 2*c)) mRise[c] <= wrData;
          if (wrAddr == AW'(17 + 2*c)) mFall[c] <= wrData;
        end
      end
      if (tLoad) begin
        mPerSh <= mPer; mPscSh <= mPsc;
        for (int c = 0; c < NCH; c++) begin
          mRiseSh[c] <= mRise[c]; mFallSh[c] <= mFall[c];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitors (sampled at negedge) ----------------
  int cyc = 0, lastSync = -1, gap = 0, syncCnt = 0, teCnt = 0, hi0 = 0, hiAll = 0;
  int ch2Hi = 0, dblSync = 0, irq0Cnt = 0, irqOther = 0;
  logic prevSync = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (modelCmp) begin
        logic [NCH-1:0] ePwm;
        ePwm = mPwm & ~{NCH{trapIn | mTrap}};
        chk(pwmOut == ePwm, "R3", "pwm levels", pwmOut, ePwm);
        chk(syncOut == mSync, "R4", "sync pulse", syncOut, mSync);
        chk(transEnOut == mTe, "R6", "transfer enable", transEnOut, mTe);
        chk(irqOut == mIrq, "R8", "irq pulses", irqOut, mIrq);
      end
      if (syncOut) begin
        if (lastSync >= 0) gap = cyc - lastSync;
        lastSync = cyc;
        syncCnt++;
        if (prevSync) dblSync++;
      end
      prevSync = syncOut;
      if (transEnOut) teCnt++;
      if (pwmOut[0]) hi0++;
      if (pwmOut != 0) hiAll++;
      if (pwmOut[2]) ch2Hi++;
      if (irqOut[0]) irq0Cnt++;
      if (irqOut[2*NCH-1:1] != 0) irqOther++;
    end
  end

  task automatic clearMon();
    syncCnt = 0; teCnt = 0; hi0 = 0; hiAll = 0; ch2Hi = 0;
    dblSync = 0; irq0Cnt = 0; irqOther = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = AW'(a); wrData = CW'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pwmOut == 0, "R1", "pwm after reset", pwmOut, 0);
    chk(syncOut == 0 && transEnOut == 0, "R1", "pulses after reset", {syncOut, transEnOut}, 0);
    chk(irqOut == 0, "R1", "irq after reset", irqOut, 0);
    idle(5);
    chk(syncOut == 0, "R1", "idle without run", syncOut, 0);
    modelCmp = 1'b1;

    // program period 9, prescale 0, six channel shapes
    wr(0, 9); wr(1, 0); wr(3, 12'hfff);
    wr(16, 2); wr(17, 6);   // ch0 plain pulse
    wr(18, 7); wr(19, 3);   // ch1 spans wrap
    wr(20, 4); wr(21, 4);   // ch2 equal edges -> low
    wr(22, 0); wr(23, 5);   // ch3 starts at zero
    wr(24, 9); wr(25, 0);   // ch4 high only at period
    wr(26, 1); wr(27, 9);
    wr(2, 5);               // run + update request
    idle(45);
    clearMon();
    idle(40);
    chk(gap == 10, "R2", "restart spacing P=9 S=0", gap, 10);
    chk(ch2Hi == 0, "R3", "equal edges stay low", ch2Hi, 0);
    chk(hi0 == 16, "R3", "ch0 high cycles in 4 periods", hi0, 16);
    chk(dblSync == 0, "R4", "sync lasts one cycle", dblSync, 0);
    chk(syncCnt == 4, "R4", "sync per period", syncCnt, 4);
    chk(teCnt == 0, "R6", "no transfer without request", teCnt, 0);

    // R5: write without request changes nothing
    wr(16, 8);
    idle(25);
    clearMon();
    idle(40);
    chk(hi0 == 16, "R5", "unarmed write no effect", hi0, 16);
    wr(2, 5);
    idle(25);
    clearMon();
    idle(40);
    chk(hi0 == 32, "R5", "armed write applied at restart", hi0, 32);
    chk(teCnt == 0, "R6", "request consumed once", teCnt, 0);

    // R2 with prescale 2
    clearMon();
    wr(1, 2); wr(2, 5);
    idle(100);
    chk(gap == 30, "R2", "restart spacing P=9 S=2", gap, 30);
    chk(teCnt == 1, "R6", "one transfer for one request", teCnt, 1);
    wr(1, 0); wr(2, 5);
    idle(30);

    // R10: external restart
    idle(3);
    extRestart = 1'b1;
    @(posedge clk); #1;
    extRestart = 1'b0;
    @(negedge clk);
    chk(syncOut == 1'b1, "R10", "sync after ext restart", syncOut, 1);
    idle(20);

    // R8: only ch0 rising interrupt enabled
    wr(3, 1);
    idle(5);
    clearMon();
    idle(40);
    chk(irq0Cnt == 4, "R8", "ch0 rise irq count", irq0Cnt, 4);
    chk(irqOther == 0, "R8", "masked irqs silent", irqOther, 0);

    // R9: trap
    trapIn = 1'b1;
    #1;
    chk(pwmOut == 0, "R9", "trap forces low at once", pwmOut, 0);
    idle(15);
    trapIn = 1'b0;
    idle(2);
    clearMon();
    idle(30);
    chk(hiAll == 0, "R9", "latched trap holds low", hiAll, 0);
    wr(2, 9);                // run + trap clear
    idle(5);
    clearMon();
    idle(30);
    chk(hiAll > 0, "R9", "outputs resume after clear", hiAll > 0, 1);

    // R7: single run
    wr(2, 3);
    idle(30);
    clearMon();
    idle(40);
    chk(syncCnt == 0, "R7", "no sync after single run", syncCnt, 0);
    chk(hiAll == 0, "R7", "outputs low when stopped", hiAll, 0);
    clearMon();
    wr(2, 3);
    idle(40);
    chk(syncCnt == 1, "R7", "one start sync in single run", syncCnt, 1);
    wr(2, 1);
    idle(10);
    wr(2, 0);
    idle(2);
    clearMon();
    idle(30);
    chk(syncCnt == 0 && hiAll == 0, "R7", "run=0 stops", syncCnt + hiAll, 0);

    // random phase, checked by the model
    wr(2, 5);
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      wrEn = 1'b0; extRestart = 1'b0;
      trapIn = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 49) == 0) extRestart = 1'b1;
      if ($urandom_range(0, 14) == 0) begin
        int sel;
        sel = $urandom_range(0, 5);
        wrEn = 1'b1;
        case (sel)
          0: begin wrAddr = 0; wrData = CW'($urandom_range(0, 15)); end
          1: begin wrAddr = 1; wrData = CW'($urandom_range(0, 3)); end
          2: begin wrAddr = 2; wrData = CW'($urandom_range(0, 15) | ($urandom_range(0, 3) != 0 ? 1 : 0)); end
          3: begin wrAddr = 3; wrData = CW'($urandom_range(0, 4095)); end
          default: begin wrAddr = AW'($urandom_range(16, 27)); wrData = CW'($urandom_range(0, 15)); end
        endcase
      end
    end
    @(posedge clk); #1;
    wrEn = 1'b0; extRestart = 1'b0; trapIn = 1'b0;
    idle(10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule